// File: doc/BRIEF.md
# Reloadable Lookup-Table Trigger Term Bank

This block checks a group of trigger conditions against every 32-bit sample a capture engine presents. There are three kinds of term: ten masked equality tests, two window tests that ask whether the sample sits between a lower and an upper limit, and two transition detectors that watch a chosen signal bit. No term holds a comparator constant. Every term is built from 16-entry truth tables, and each table is indexed by one 4-bit nibble of the sample. The host computes the table bits itself and can rewrite them at any time while the block runs.

Loading uses two strobes. The first picks a term, which means one serial chain of table bits. The second hands over a 32-bit word, and the block shifts that word into the chosen chain one bit per clock. The per-term hit flags come out of a register one cycle after the sample that produced them. Every cycle that would expose a half-loaded table reports no hits.

Top module: `trig_term_bank`

## Requirements
- R1: While reset is held and right after it is released, `hitFlags`, `hitValid` and `cfgBusy` are all 0, and every table bit is 0.
- R2: Flag k, for k in 0..9, is 1 when for every nibble n (0..7) chain bit 16n+i is 1, where i is the value of sample bits [4n+3:4n]. A table entry set to ((i xor target) and mask)==0 therefore turns the term into a masked equality test.
- R3: Flags 10 and 11 are window tests on a 512-bit chain. The table at bits 16n is a lower-limit "greater" table, at 128+16n a lower-limit "equal" table, at 256+16n an upper-limit "less" table and at 384+16n an upper-limit "equal" table. Two carries run from nibble 0 up to nibble 7, each starting at 1 and following c = greater | (equal & c), using the "less" table for the upper carry. The flag is the AND of the two final carries.
- R4: With tables filled from limits lo and hi, a window flag is 1 for lo <= sample <= hi. Both limits count as inside, and lo equal to hi accepts exactly one value.
- R5: Flags 12 and 13 are transition detectors on a 132-bit chain. The level is the OR over nibbles of chain bit 16n+i, where i is sample nibble n. The flag is chain bit 128 + 2*prev + cur, where prev is the level of the previous valid sample (0 after reset). Writing 4'b0010, 4'b0100, 4'b0110 or 4'b0000 there selects rising, falling, both or neither.
- R6: `hitValid` and `hitFlags` show the result of a sample in the cycle after `sampleValid` was high. After a cycle with `sampleValid` low, `hitValid` is 0 and `hitFlags` is 0.
- R7: A `cfgWrStrobe` accepted while idle raises `cfgBusy` on the next cycle and holds it for exactly 32 cycles. During that time the word is shifted in most significant bit first, one bit per clock.
- R8: Each shifted bit enters the selected chain at bit 0 and every existing bit moves up one place, so chain <= {chain[LEN-2:0], bit}. No other chain changes.
- R9: Any result computed in a cycle with `cfgBusy` high is reported as all flags 0.
- R10: `cfgSelStrobe` and `cfgWrStrobe` are ignored while `cfgBusy` is high. A select and a write in the same idle cycle shift into the newly selected term.
- R11: A select address of 14 or 15 names no chain, so a following write changes no term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Marks a sample to evaluate |
| sampleData | input | 32 | Sample word |
| cfgSelStrobe | input | 1 | Latch `cfgSelAddr` as the target term |
| cfgSelAddr | input | 4 | Term index: 0-9 equality, 10-11 window, 12-13 transition |
| cfgWrStrobe | input | 1 | Start shifting `cfgWrWord` into the selected chain |
| cfgWrWord | input | 32 | Configuration word, shifted MSB first |
| cfgBusy | output | 1 | Shift in progress |
| hitValid | output | 1 | `hitFlags` belongs to a sample |
| hitFlags | output | 14 | One hit bit per term |

## Verification
The assertions assume that the host only raises `cfgWrStrobe` when it wants a shift, and that samples may arrive in any cycle, including while a shift is running. The busy-length and suppression properties therefore hold for any such input. The stimulus starts each load only after it has seen `cfgBusy` low. It deliberately sends strobes and samples during a shift to exercise the ignore and suppression rules. After every reload of a transition table it sends one unchecked priming sample, so that the stored previous level matches the new tables before any result is judged.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int NIB_W = 4;
  localparam int TAB_D = 1 << NIB_W;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic holdOff;
  } cfgStrobe_t;
endpackage

// File: rtl/trig_term_ctrl.sv
module trig_term_ctrl
  import trig_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSelStrobe,
  input  logic [SEL_W-1:0]  cfgSelAddr,
  input  logic              cfgWrStrobe,
  input  logic [WORD_W-1:0] cfgWrWord,
  output cfgStrobe_t        strobe,
  output logic [SEL_W-1:0]  termSel,
  output logic              busy
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] wordReg;
  logic [CNT_W-1:0]  bitsLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReg  <= '0;
      bitsLeft <= '0;
      termSel  <= '0;
    end else if (bitsLeft != '0) begin
      wordReg  <= wordReg << 1;
      bitsLeft <= bitsLeft - 1'b1;
    end else begin
      if (cfgSelStrobe) termSel <= cfgSelAddr;
      if (cfgWrStrobe) begin
        wordReg  <= cfgWrWord;
        bitsLeft <= CNT_W'(WORD_W);
      end
    end
  end

  assign busy = (bitsLeft != '0);

  always_comb begin
    strobe.shiftEn  = busy;
    strobe.shiftBit = wordReg[WORD_W-1];
    strobe.holdOff  = busy;
  end
endmodule

// File: rtl/trig_term_datapath.sv
module trig_term_datapath
  import trig_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_MATCH = 10,
  parameter int NUM_RANGE = 2,
  parameter int NUM_EDGE  = 2,
  parameter int SEL_W     = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   sampleValid,
  input  logic [DATA_W-1:0]                      sampleData,
  input  cfgStrobe_t                             strobe,
  input  logic [SEL_W-1:0]                       termSel,
  output logic                                   hitValid,
  output logic [NUM_MATCH+NUM_RANGE+NUM_EDGE-1:0] hitFlags
);
  localparam int NIBS      = DATA_W / NIB_W;
  localparam int GRP       = NIBS * TAB_D;
  localparam int MATCH_LEN = GRP;
  localparam int RANGE_LEN = 4 * GRP;
  localparam int EDGE_LEN  = GRP + 4;
  localparam int NUM_TERMS = NUM_MATCH + NUM_RANGE + NUM_EDGE;
  localparam int RANGE_BASE = NUM_MATCH;
  localparam int EDGE_BASE  = NUM_MATCH + NUM_RANGE;

  logic [NUM_TERMS-1:0] termHit;

  for (genvar m = 0; m < NUM_MATCH; m++) begin : gMatch
    logic [MATCH_LEN-1:0] chain;
    logic hit;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else if (strobe.shiftEn && termSel == SEL_W'(m))
        chain <= {chain[MATCH_LEN-2:0], strobe.shiftBit};
    end
    always_comb begin
      hit = 1'b1;
      for (int n = 0; n < NIBS; n++) begin
        hit = hit & chain[n*TAB_D + int'(sampleData[n*NIB_W +: NIB_W])];
      end
    end
    assign termHit[m] = hit;
  end

  for (genvar r = 0; r < NUM_RANGE; r++) begin : gRange
    logic [RANGE_LEN-1:0] chain;
    logic geCarry, leCarry;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else if (strobe.shiftEn && termSel == SEL_W'(RANGE_BASE + r))
        chain <= {chain[RANGE_LEN-2:0], strobe.shiftBit};
    end
    always_comb begin
      geCarry = 1'b1;
      leCarry = 1'b1;
      for (int n = 0; n < NIBS; n++) begin
        geCarry = chain[n*TAB_D + int'(sampleData[n*NIB_W +: NIB_W])]
                | (chain[GRP + n*TAB_D + int'(sampleData[n*NIB_W +: NIB_W])] & geCarry);
        leCarry = chain[2*GRP + n*TAB_D + int'(sampleData[n*NIB_W +: NIB_W])]
                | (chain[3*GRP + n*TAB_D + int'(sampleData[n*NIB_W +: NIB_W])] & leCarry);
      end
    end
    assign termHit[RANGE_BASE + r] = geCarry & leCarry;
  end

  for (genvar e = 0; e < NUM_EDGE; e++) begin : gEdge
    logic [EDGE_LEN-1:0] chain;
    logic curLevel, prevLevel;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else if (strobe.shiftEn && termSel == SEL_W'(EDGE_BASE + e))
        chain <= {chain[EDGE_LEN-2:0], strobe.shiftBit};
    end
    always_comb begin
      curLevel = 1'b0;
      for (int n = 0; n < NIBS; n++) begin
        curLevel = curLevel | chain[n*TAB_D + int'(sampleData[n*NIB_W +: NIB_W])];
      end
    end
    always_ff @(posedge clk) begin
      if (!rstN) prevLevel <= 1'b0;
      else if (sampleValid) prevLevel <= curLevel;
    end
    assign termHit[EDGE_BASE + e] = chain[GRP + int'({prevLevel, curLevel})];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitValid <= 1'b0;
      hitFlags <= '0;
    end else begin
      hitValid <= sampleValid;
      hitFlags <= (sampleValid && !strobe.holdOff) ? termHit : '0;
    end
  end
endmodule

// File: rtl/trig_term_bank.sv
module trig_term_bank
  import trig_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int WORD_W    = 32,
  parameter int NUM_MATCH = 10,
  parameter int NUM_RANGE = 2,
  parameter int NUM_EDGE  = 2
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         sampleValid,
  input  logic [DATA_W-1:0]                            sampleData,
  input  logic                                         cfgSelStrobe,
  input  logic [$clog2(NUM_MATCH+NUM_RANGE+NUM_EDGE)-1:0] cfgSelAddr,
  input  logic                                         cfgWrStrobe,
  input  logic [WORD_W-1:0]                            cfgWrWord,
  output logic                                         cfgBusy,
  output logic                                         hitValid,
  output logic [NUM_MATCH+NUM_RANGE+NUM_EDGE-1:0]      hitFlags
);
  localparam int NUM_TERMS = NUM_MATCH + NUM_RANGE + NUM_EDGE;
  localparam int SEL_W     = $clog2(NUM_TERMS);

  cfgStrobe_t       strobe;
  logic [SEL_W-1:0] termSel;

  trig_term_ctrl #(.WORD_W(WORD_W), .SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgSelStrobe(cfgSelStrobe), .cfgSelAddr(cfgSelAddr),
    .cfgWrStrobe(cfgWrStrobe), .cfgWrWord(cfgWrWord),
    .strobe(strobe), .termSel(termSel), .busy(cfgBusy)
  );

  trig_term_datapath #(
    .DATA_W(DATA_W), .NUM_MATCH(NUM_MATCH), .NUM_RANGE(NUM_RANGE),
    .NUM_EDGE(NUM_EDGE), .SEL_W(SEL_W)
  ) uPath (
    .clk(clk), .rstN(rstN),
    .sampleValid(sampleValid), .sampleData(sampleData),
    .strobe(strobe), .termSel(termSel),
    .hitValid(hitValid), .hitFlags(hitFlags)
  );
endmodule

// File: rtl/trig_term_bank_chk.sv
module trig_term_bank_chk #(
  parameter int WORD_W    = 32,
  parameter int NUM_TERMS = 14
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sampleValid,
  input logic                 cfgWrStrobe,
  input logic                 cfgBusy,
  input logic                 hitValid,
  input logic [NUM_TERMS-1:0] hitFlags
);
  logic [15:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= '0;
    else busyRun <= cfgBusy ? busyRun + 16'd1 : 16'd0;
  end

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgBusy |=> (hitFlags == '0));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> (hitFlags == '0) && !hitValid);

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> hitValid);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgBusy) |-> $past(cfgWrStrobe));

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgBusy) |-> (busyRun == 16'(WORD_W)));
endmodule

bind trig_term_bank trig_term_bank_chk #(
  .WORD_W(WORD_W), .NUM_TERMS(NUM_MATCH + NUM_RANGE + NUM_EDGE)
) uChk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
  .cfgWrStrobe(cfgWrStrobe), .cfgBusy(cfgBusy),
  .hitValid(hitValid), .hitFlags(hitFlags)
);

// File: tb/sim_trig_term_bank.sv
module sim_trig_term_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [31:0] sampleData = '0;
  logic        cfgSelStrobe = 1'b0;
  logic [3:0]  cfgSelAddr = '0;
  logic        cfgWrStrobe = 1'b0;
  logic [31:0] cfgWrWord = '0;
  logic        cfgBusy, hitValid;
  logic [13:0] hitFlags;

  int checks = 0;
  int errors = 0;

  logic [31:0] tgt [10];
  logic [31:0] msk [10];
  logic [31:0] lo [2];
  logic [31:0] hi [2];
  int          edgeBit [2];
  logic [3:0]  edgeMode [2];
  logic        prevL [2];

  trig_term_bank u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .cfgSelStrobe(cfgSelStrobe), .cfgSelAddr(cfgSelAddr),
    .cfgWrStrobe(cfgWrStrobe), .cfgWrWord(cfgWrWord),
    .cfgBusy(cfgBusy), .hitValid(hitValid), .hitFlags(hitFlags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic selectTerm(input int a);
    @(negedge clk) cfgSelStrobe = 1'b1; cfgSelAddr = 4'(a);
    @(negedge clk) cfgSelStrobe = 1'b0;
  endtask

  task automatic writeWord(input logic [31:0] w);
    @(negedge clk) cfgWrStrobe = 1'b1; cfgWrWord = w;
    @(negedge clk) cfgWrStrobe = 1'b0;
    while (cfgBusy) @(negedge clk);
  endtask

  task automatic loadChain(input int term, input logic [511:0] v, input int nWords);
    selectTerm(term);
    for (int w = 0; w < nWords; w++) writeWord(v[nWords*32 - 32 - 32*w +: 32]);
  endtask

  function automatic logic [511:0] matchVec(input logic [31:0] t, input logic [31:0] m);
    logic [511:0] v = '0;
    for (int n = 0; n < 8; n++)
      for (int i = 0; i < 16; i++)
        v[16*n+i] = (((4'(i) ^ t[4*n +: 4]) & m[4*n +: 4]) == 4'h0);
    return v;
  endfunction

  function automatic logic [511:0] rangeVec(input logic [31:0] l, input logic [31:0] h);
    logic [511:0] v = '0;
    for (int n = 0; n < 8; n++)
      for (int i = 0; i < 16; i++) begin
        v[16*n+i]     = (4'(i) > l[4*n +: 4]);
        v[128+16*n+i] = (4'(i) == l[4*n +: 4]);
        v[256+16*n+i] = (4'(i) < h[4*n +: 4]);
        v[384+16*n+i] = (4'(i) == h[4*n +: 4]);
      end
    return v;
  endfunction

  function automatic logic [511:0] edgeVec(input int b, input logic [3:0] mode);
    logic [511:0] v = '0;
    for (int i = 0; i < 16; i++) v[16*(b/4)+i] = 1'((i >> (b%4)) & 1);
    v[128 +: 4] = mode;
    return v;
  endfunction

  function automatic logic [13:0] expOf(input logic [31:0] d);
    logic [13:0] e;
    for (int k = 0; k < 10; k++) e[k] = (((d ^ tgt[k]) & msk[k]) == 32'h0);
    for (int r = 0; r < 2; r++) e[10+r] = (d >= lo[r]) && (d <= hi[r]);
    for (int g = 0; g < 2; g++) e[12+g] = edgeMode[g][{prevL[g], d[edgeBit[g]]}];
    return e;
  endfunction

  task automatic updatePrev(input logic [31:0] d);
    for (int g = 0; g < 2; g++) prevL[g] = d[edgeBit[g]];
  endtask

  task automatic applySample(input logic [31:0] d, output logic [13:0] got);
    @(negedge clk) sampleValid = 1'b1; sampleData = d;
    @(negedge clk) sampleValid = 1'b0;
    got = hitFlags;
    checks++;
    if (hitValid !== 1'b1) begin
      errors++;
      $display("FAIL R6 hitValid actual %b expected 1", hitValid);
    end
  endtask

  task automatic fullCheck(input logic [31:0] d);
    logic [13:0] got, exp;
    exp = expOf(d);
    applySample(d, got);
    chk("R2 equality terms", 32'(got[9:0]), 32'(exp[9:0]));
    chk("R3 R4 window terms", 32'(got[11:10]), 32'(exp[11:10]));
    chk("R5 transition terms", 32'(got[13:12]), 32'(exp[13:12]));
    updatePrev(d);
  endtask

  logic [31:0] lcg = 32'h1357_9BDF;
  function automatic logic [31:0] nextRand(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    logic [13:0] got;
    logic        prevBusy;
    int          busyLen;
    for (int k = 0; k < 10; k++) begin
      tgt[k] = 32'h9E37_79B9 * (k + 1);
      msk[k] = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'h0 : ~(32'h0F0F_00F0 >> k);
    end
    lo[0] = 32'h1000_0000; hi[0] = 32'h1000_00FF;
    lo[1] = 32'h0000_0010; hi[1] = 32'h0000_0010;
    edgeBit[0] = 5;  edgeMode[0] = 4'b0010;
    edgeBit[1] = 30; edgeMode[1] = 4'b0110;
    prevL[0] = 1'b0; prevL[1] = 1'b0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 flags in reset", 32'(hitFlags), 32'h0);
    chk("R1 busy in reset", 32'(cfgBusy), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 flags after reset", 32'(hitFlags), 32'h0);
    chk("R1 hitValid after reset", 32'(hitValid), 32'h0);
    // R1: cleared tables give no equality or window hit
    applySample(32'hDEAD_BEEF, got);
    chk("R1 empty tables", 32'(got[11:0]), 32'h0);
    updatePrev(32'hDEAD_BEEF);
    @(negedge clk);
    // R6: idle cycle
    chk("R6 idle flags", 32'(hitFlags), 32'h0);
    chk("R6 idle valid", 32'(hitValid), 32'h0);

    // R8: load all chains
    for (int k = 0; k < 10; k++) loadChain(k, matchVec(tgt[k], msk[k]), 4);
    for (int r = 0; r < 2; r++) loadChain(10 + r, rangeVec(lo[r], hi[r]), 16);
    for (int g = 0; g < 2; g++) loadChain(12 + g, edgeVec(edgeBit[g], edgeMode[g]), 5);
    applySample(32'h0, got);
    updatePrev(32'h0);

    // R2: sweep around every target, single-bit flips
    for (int k = 0; k < 10; k++)
      for (int v = 0; v < 36; v++) begin
        lcg = nextRand(lcg);
        fullCheck(v == 0 ? tgt[k] : (v <= 32) ? tgt[k] ^ (32'h1 << (v - 1)) : lcg);
      end
    // R4: window boundaries
    for (int r = 0; r < 2; r++) begin
      fullCheck(lo[r] - 1); fullCheck(lo[r]); fullCheck(lo[r] + 1);
      fullCheck(hi[r] - 1); fullCheck(hi[r]); fullCheck(hi[r] + 1);
    end
    // R5: transitions on watched bits
    for (int s = 0; s < 16; s++) fullCheck(((s & 1) ? 32'h20 : 32'h0) | ((s & 2) ? 32'h4000_0000 : 32'h0));

    // R5: every transition mode on term 12
    for (int md = 0; md < 4; md++) begin
      edgeMode[0] = (md == 0) ? 4'b0000 : (md == 1) ? 4'b0010 : (md == 2) ? 4'b0100 : 4'b0110;
      loadChain(12, edgeVec(edgeBit[0], edgeMode[0]), 5);
      applySample(32'h0, got);
      updatePrev(32'h0);
      for (int s = 0; s < 6; s++) fullCheck((s % 3 == 0) ? 32'h0 : 32'h20);
    end

    // R7 R9 R11: write to an unused address with samples running
    selectTerm(15);
    @(negedge clk) cfgWrStrobe = 1'b1; cfgWrWord = 32'hFFFF_FFFF;
    sampleValid = 1'b1; sampleData = tgt[3];
    @(negedge clk) cfgWrStrobe = 1'b0;
    busyLen = 0;
    prevBusy = 1'b0;
    while (cfgBusy) begin
      if (prevBusy) chk("R9 flags during shift", 32'(hitFlags), 32'h0);
      prevBusy = 1'b1;
      busyLen++;
      @(negedge clk);
    end
    chk("R9 flags after last shift", 32'(hitFlags), 32'h0);
    sampleValid = 1'b0;
    updatePrev(tgt[3]);
    chk("R7 busy length", 32'(busyLen), 32'd32);
    // R11: nothing changed
    for (int v = 0; v < 8; v++) fullCheck(tgt[v] ^ (32'h1 << v));
    fullCheck(lo[0]); fullCheck(hi[1]);

    // R10: strobes during shift ignored
    selectTerm(0);
    @(negedge clk) cfgWrStrobe = 1'b1; cfgWrWord = 32'hFFFF_FFFF;
    @(negedge clk) cfgWrStrobe = 1'b0;
    repeat (3) @(negedge clk);
    cfgSelStrobe = 1'b1; cfgSelAddr = 4'd2; cfgWrStrobe = 1'b1; cfgWrWord = 32'h0;
    @(negedge clk) cfgSelStrobe = 1'b0; cfgWrStrobe = 1'b0;
    busyLen = 4;
    while (cfgBusy) begin busyLen++; @(negedge clk); end
    chk("R10 busy not extended", 32'(busyLen), 32'd32);
    // R8 R10: term 0 tables moved up two nibbles, low two always hit
    for (int v = 0; v < 12; v++) begin
      logic [31:0] d;
      logic        e0;
      lcg = nextRand(lcg);
      d = (v < 6) ? ((tgt[0] << 8) | (lcg & 32'hFF)) : ((tgt[0] << 8) ^ (32'h100 << v));
      e0 = ((((d >> 8) ^ tgt[0]) & 32'h00FF_FFFF) == 32'h0);
      applySample(d, got);
      chk("R8 R10 shifted term 0", 32'(got[0]), 32'(e0));
      chk("R10 term 2 unchanged", 32'(got[2]), 32'(((d ^ tgt[2]) & msk[2]) == 32'h0));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule